// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block holds the array address of a synchronous burst memory. Two separate burst-start strobes share one address input. Either strobe, when the chip enable is also high, captures the external address at the rising clock edge and starts a new burst. After that, each clock with the advance input high steps a 2-bit beat count. The two least significant address bits are then remapped from the captured start value. The upper address bits never change during a burst. Bursting is optional: a new address can be captured on every cycle.

A static order input chooses how the low bits move. In linear order the beat count is added to the start value modulo 4. In interleaved order the beat count is XORed with the start value. A sleep input freezes the whole state, so an interrupted burst continues where it stopped. The address output comes straight from registers and the order input, and it is valid on every cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and right after it is released, `addr_out` is all zeros and the beat count is 0.
- R2: When `chip_en` is 1, `sleep` is 0, and at least one of `start_a` or `start_b` is 1 at a rising edge, `addr_out` equals `addr_in` after that edge.
- R3: A start strobe at an edge where `chip_en` is 0 is ignored. The address and beat count keep their previous values.
- R4: With `linear_order` = 1, the low two bits of `addr_out` equal (start low bits + beat count) mod 4. The beat count rises by one at each edge where `adv` is 1 and no load happens.
- R5: With `linear_order` = 0 (interleaved order, the default encoding), the low two bits of `addr_out` equal start low bits XOR beat count.
- R6: Bits above bit 1 of `addr_out` stay fixed for the whole burst. After four advances the beat count wraps back to 0, so `addr_out` returns to the start address.
- R7: At an edge with no qualified start, no `adv` and no `sleep`, `addr_out` holds its value.
- R8: When a qualified start and `adv` are both high at the same edge, the load wins. The new address appears with beat count 0.
- R9: At an edge where `sleep` is 1, the start strobes and `adv` are ignored. The address and beat count are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| chip_en | input | 1 | Qualifies both start strobes |
| start_a | input | 1 | First burst-start strobe |
| start_b | input | 1 | Second burst-start strobe |
| adv | input | 1 | Advance the beat count |
| linear_order | input | 1 | 1 = linear order, 0 = interleaved order |
| sleep | input | 1 | Freeze all state |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current array address |

## Verification
A wrong base register shows up in the upper bits of `addr_out` one edge after the bad load or hold. A wrong beat count, or a wrong order mapping, shows up in the two low bits at the first advance after the fault. The same fault also appears four advances later, when the address fails to return to the start value. Each edge is compared against a bench model of base and beat. Strobes gated by `chip_en`, `sleep` or a same-edge advance are among the stimuli, so a qualification fault is caught one edge after the stimulus.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  localparam int unsigned BEAT_W = 2;

  typedef enum logic {
    ORDER_XOR = 1'b0,
    ORDER_ADD = 1'b1
  } burst_order_e;

  typedef logic [BEAT_W-1:0] beat_t;

  function automatic beat_t map_low(input beat_t start, input beat_t beat,
                                    input burst_order_e order);
    beat_t res;
    if (order == ORDER_ADD) res = start + beat;
    else                    res = start ^ beat;
    return res;
  endfunction
endpackage

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl (
  input  logic chip_en,
  input  logic start_a,
  input  logic start_b,
  input  logic adv,
  input  logic sleep,
  output logic load_en,
  output logic step_en
);
  logic strobe_any;

  always_comb begin
    strobe_any = start_a | start_b;
    load_en    = ~sleep & chip_en & strobe_any;
    step_en    = ~sleep & adv & ~load_en;
  end
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
  import burst_addr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  logic  step_en,
  output beat_t beat
);
  beat_t beat_q, beat_d;

  always_comb begin
    beat_d = beat_q;
    if (load_en)      beat_d = '0;
    else if (step_en) beat_d = beat_q + beat_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  beat_q <= '0;
    else if (load_en | step_en)  beat_q <= beat_d;
  end

  assign beat = beat_q;
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base
);
  logic [ADDR_W-1:0] base_q, base_d;

  always_comb begin
    base_d = base_q;
    if (load_en) base_d = addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (load_en) base_q <= base_d;
  end

  assign base = base_q;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              start_a,
  input  logic              start_b,
  input  logic              adv,
  input  logic              linear_order,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  logic              load_en;
  logic              step_en;
  beat_t             beat;
  logic [ADDR_W-1:0] base;
  beat_t             low_bits;
  burst_order_e      order;

  burst_load_ctrl u_ctrl (
    .chip_en (chip_en),
    .start_a (start_a),
    .start_b (start_b),
    .adv     (adv),
    .sleep   (sleep),
    .load_en (load_en),
    .step_en (step_en)
  );

  burst_beat_counter u_beat (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .step_en (step_en),
    .beat    (beat)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .addr_in (addr_in),
    .base    (base)
  );

  always_comb begin
    order    = linear_order ? ORDER_ADD : ORDER_XOR;
    low_bits = map_low(base[BEAT_W-1:0], beat, order);
    addr_out = {base[ADDR_W-1:BEAT_W], low_bits};
  end

  if (HI_W < 1) begin : g_width_guard
    initial $error("burst_addr_gen: ADDR_W must exceed the beat width");
  end
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int unsigned ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_en,
  input logic              start_a,
  input logic              start_b,
  input logic              adv,
  input logic              linear_order,
  input logic              sleep,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out
);
  logic qual_load;
  assign qual_load = chip_en & (start_a | start_b) & ~sleep;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    qual_load |=> addr_out == $past(addr_in))
    else $error("R2 load mismatch");

  assert_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_en && !adv && !sleep) ##1 $stable(linear_order) |-> $stable(addr_out))
    else $error("R3 ungated strobe moved address");

  assert_linear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !qual_load && !sleep && linear_order) ##1 linear_order |->
      addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1))
    else $error("R4 linear step wrong");

  assert_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !qual_load |=> $stable(addr_out[ADDR_W-1:2]))
    else $error("R6 upper bits moved");

  assert_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep ##1 $stable(linear_order) |-> $stable(addr_out))
    else $error("R9 state moved in sleep");
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .chip_en      (chip_en),
  .start_a      (start_a),
  .start_b      (start_b),
  .adv          (adv),
  .linear_order (linear_order),
  .sleep        (sleep),
  .addr_in      (addr_in),
  .addr_out     (addr_out)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
  localparam int unsigned AW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          chip_en, start_a, start_b, adv, linear_order, sleep;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;

  logic [AW-1:0] m_base;
  logic [1:0]    m_beat;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .start_a(start_a),
    .start_b(start_b), .adv(adv), .linear_order(linear_order),
    .sleep(sleep), .addr_in(addr_in), .addr_out(addr_out)
  );

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b,
                                             input logic [1:0] k,
                                             input logic lin);
    logic [1:0] lo;
    lo = lin ? 2'(b[1:0] + k) : (b[1:0] ^ k);
    return {b[AW-1:2], lo};
  endfunction

  task automatic compare(input string tag);
    logic [AW-1:0] e;
    e = exp_addr(m_base, m_beat, linear_order);
    n_cmp++;
    if (addr_out !== e) begin
      n_bad++;
      $display("FAIL %s: addr_out=%h expected=%h", tag, addr_out, e);
    end
  endtask

  // Apply inputs, pass one rising edge, update the model, compare 2 ns later.
  task automatic cycle(input logic ce, input logic sa, input logic sb,
                       input logic ad, input logic sl, input logic [AW-1:0] a);
    string tag;
    logic  ld;
    chip_en = ce; start_a = sa; start_b = sb; adv = ad; sleep = sl; addr_in = a;
    ld = ce & (sa | sb) & ~sl;
    if (sl)                tag = "R9";
    else if (ld && ad)     tag = "R8";
    else if (ld)           tag = "R2";
    else if ((sa | sb))    tag = "R3";
    else if (ad)           tag = (m_beat == 2'd3) ? "R6" : (linear_order ? "R4" : "R5");
    else                   tag = "R7";
    @(posedge clk);
    if (ld) begin
      m_base = a; m_beat = 2'd0;
    end else if (ad && !sl) begin
      m_beat = m_beat + 2'd1;
    end
    #2;
    compare(tag);
  endtask

  initial begin
    #150000;
    n_bad++;
    $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5eed_0b57);
    rst_n = 1'b0; chip_en = 0; start_a = 0; start_b = 0; adv = 0;
    linear_order = 0; sleep = 0; addr_in = '0;
    m_base = '0; m_beat = '0;
    repeat (3) @(posedge clk);
    #2; compare("R1");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2; compare("R1");

    // Directed: interleaved burst from low bits 2, full wrap (R5, R6).
    cycle(1, 1, 0, 0, 0, 18'h2A5F6);
    for (int i = 0; i < 4; i++) cycle(0, 0, 0, 1, 0, '0);
    // Linear burst via second strobe from low bits 3 (R4, R6).
    linear_order = 1;
    cycle(1, 0, 1, 0, 0, 18'h13337);
    for (int i = 0; i < 4; i++) cycle(0, 0, 0, 1, 0, '0);
    // Strobe without chip enable (R3), hold (R7), sleep (R9), load beats adv (R8).
    cycle(0, 1, 1, 0, 0, 18'h3FFFF);
    cycle(1, 0, 0, 0, 0, 18'h00001);
    cycle(1, 1, 1, 1, 1, 18'h0ABCD);
    cycle(0, 0, 0, 1, 1, '0);
    cycle(1, 1, 0, 1, 0, 18'h0ABCD);
    cycle(0, 0, 0, 1, 0, '0);
    linear_order = 0;
    cycle(0, 0, 0, 0, 0, '0);

    // Random mix.
    for (int i = 0; i < 600; i++) begin
      logic ce, sa, sb, ad, sl;
      ce = ($urandom % 4) != 0;
      sa = ($urandom % 5) == 0;
      sb = ($urandom % 5) == 0;
      ad = ($urandom % 2) == 0;
      sl = ($urandom % 10) == 0;
      if (($urandom % 10) == 0) linear_order = ~linear_order;
      cycle(ce, sa, sb, ad, sl, AW'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule